// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue Manager

This block keeps many independent circular queues inside one shared on-chip SRAM of 32-bit words. Each queue has its own base word address, its own capacity counted in entries, and an entry width of one, two or four words. The block tracks a read pointer, a write pointer and an occupancy count for every queue, and it derives that queue's status flags from them. A single memory-mapped port carries queue pushes and pops, configuration and status accesses, and direct reads and writes of the SRAM.

A requester waits for `bus_ready`, presents one request for one cycle, and then waits for the one-cycle `bus_ack`. At the acknowledge, read data is valid on `bus_rdata`. A control state machine runs every access. In IDLE it accepts a request. The transition IDLE->MOVE is taken by a push to a queue that is not full, or by a pop from a queue that is not empty. The transition IDLE->DONE is taken by every other access, including a discarded push and an empty pop. MOVE stays in MOVE and moves one word per cycle until the last word of the entry has moved. It then takes MOVE->DONE and commits the pointer update. DONE raises the acknowledge and returns to IDLE (DONE->IDLE).

Status leaves the block on three paths. The lower half of the queues each drive a four-bit flag group. Any non-empty queue in the upper half raises a single event line. Each half has an interrupt: the OR of the flags that are enabled for the queues in that half.

Top module: `qmgr_top`

## Requirements
- R1: After reset, `bus_ready` is 1. `evt_hi`, `irq_lo` and `irq_hi` are 0. Every queue has zero capacity, so each lower-half flag group reads 4'hB. The geometry register reads 0 and the threshold register reads 0x0000FF00.
- R2: The bus address field [12:11] selects the region: 0 is queue data, 1 is configuration, 2 is raw SRAM. In the configuration region, [7:2] is the queue and [1:0] the register. Register 0 is geometry: capacity in [7:0], entry size code in [9:8] (0, 1 or 2 gives 1, 2 or 4 words), base word address in [26:16]. Writing register 0 also clears that queue's pointers, count and overflow bit.
- R3: A push to the queue-data region (queue number in [5:0]) stores one whole entry, taking word k from `bus_wdata[32k+31:32k]`. A pop returns entries in push order. Lanes beyond the entry size read as zero.
- R4: Entry n of a queue occupies the SRAM words from base + n*entry_words upward. Read and write pointers wrap to 0 after the last entry of the configured capacity.
- R5: A pop from an empty queue returns zero and leaves the pointers unchanged.
- R6: A push to a full queue is discarded and sets that queue's sticky overflow bit. Writing register 2 of that queue clears the bit.
- R7: Register 2 reads the count in [7:0], empty in [16], full in [17], near-empty in [18], near-full in [19] and overflow in [20]. Register 1 holds the near-empty threshold in [7:0], the near-full threshold in [15:8] and the interrupt enables in [19:16]. Near-empty means count <= its threshold; near-full means count >= its threshold.
- R8: `flag_lo[4q+3:4q]` carries {full, near-full, near-empty, empty} of lower queue q.
- R9: `evt_hi` is 1 exactly when at least one upper-half queue holds an entry.
- R10: Each half's interrupt is the OR, over its queues, of the flags selected by the enables, where enable bit k matches flag bit k of the R8 group.
- R11: Raw-region accesses write and read the SRAM word at address [10:0] directly.
- R12: `bus_ready` is 1 only in IDLE. An accepted request leaves IDLE at the next edge. `bus_ack` is a single-cycle pulse, and IDLE follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, taken while bus_ready is 1 |
| bus_we | input | 1 | 1 = write/push, 0 = read/pop |
| bus_addr | input | 13 | Region, queue and register select |
| bus_wdata | input | 128 | Write data, four 32-bit lanes |
| bus_ready | output | 1 | Block is idle and can take a request |
| bus_ack | output | 1 | Access finished; read data valid |
| bus_rdata | output | 128 | Read data, four 32-bit lanes |
| flag_lo | output | 128 | Flag groups of the lower 32 queues |
| evt_hi | output | 1 | Some upper queue is non-empty |
| irq_lo | output | 1 | Interrupt for the lower half |
| irq_hi | output | 1 | Interrupt for the upper half |

## Verification
The handshake properties assume that a requester raises `bus_req` only while `bus_ready` is 1. They also assume it holds address and data steady only for that single cycle. The driver task waits for ready at a falling edge, drives the request for exactly one cycle, and returns only after the acknowledge. At most one access is therefore ever in flight. Queue geometries are written before use, with capacities of at least one entry and regions that do not overlap. Raw SRAM reads touch only words that were written earlier, so no undefined memory contents reach the compared data.

// File: rtl/qmgr_pkg.sv
package qmgr_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = 4;
    localparam int unsigned FLAG_W = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_DONE} qm_state_e;

    typedef enum logic [1:0] {
        RG_QUEUE = 2'd0,
        RG_CFG   = 2'd1,
        RG_RAW   = 2'd2,
        RG_NONE  = 2'd3
    } qm_region_e;

    typedef struct packed {
        logic full;
        logic near_full;
        logic near_empty;
        logic empty;
    } qm_flags_t;
endpackage

// File: rtl/qmgr_sram.sv
module qmgr_sram #(
    parameter int unsigned WORDS = 2048,
    parameter int unsigned DW    = 32,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/qmgr_qfile.sv
module qmgr_qfile import qmgr_pkg::*; #(
    parameter int unsigned NQ = 64,
    parameter int unsigned AW = 11,
    parameter int unsigned CW = 8,
    localparam int unsigned QW = $clog2(NQ),
    localparam int unsigned DW = 16 + AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [QW-1:0]      qsel,
    input  logic               geom_we,
    input  logic               thr_we,
    input  logic               ovf_clr,
    input  logic               ovf_set,
    input  logic               push_done,
    input  logic               pop_done,
    input  logic [DW-1:0]      cfg_data,
    output logic [AW-1:0]      sel_base,
    output logic [CW-1:0]      sel_nent,
    output logic [1:0]         sel_esz,
    output logic [CW-1:0]      sel_rptr,
    output logic [CW-1:0]      sel_wptr,
    output logic [CW-1:0]      sel_cnt,
    output logic [CW-1:0]      sel_ne_th,
    output logic [CW-1:0]      sel_nf_th,
    output logic [FLAG_W-1:0]  sel_ien,
    output logic               sel_ovf,
    output qm_flags_t          sel_flags,
    output logic [NQ*FLAG_W-1:0] flags_all,
    output logic [NQ*FLAG_W-1:0] ien_all
);
    logic [AW-1:0]     base_r [NQ];
    logic [CW-1:0]     nent_r [NQ];
    logic [1:0]        esz_r  [NQ];
    logic [CW-1:0]     rptr_r [NQ];
    logic [CW-1:0]     wptr_r [NQ];
    logic [CW-1:0]     cnt_r  [NQ];
    logic [CW-1:0]     ne_r   [NQ];
    logic [CW-1:0]     nf_r   [NQ];
    logic [FLAG_W-1:0] ien_r  [NQ];
    logic              ovf_r  [NQ];

    function automatic logic [CW-1:0] step(input logic [CW-1:0] p, input logic [CW-1:0] lim);
        return (p == lim - 1'b1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                base_r[i] <= '0; nent_r[i] <= '0; esz_r[i] <= '0;
                rptr_r[i] <= '0; wptr_r[i] <= '0; cnt_r[i] <= '0;
                ne_r[i]   <= '0; nf_r[i]   <= '1; ien_r[i] <= '0;
                ovf_r[i]  <= 1'b0;
            end
        end else begin
            if (geom_we) begin
                nent_r[qsel] <= cfg_data[CW-1:0];
                esz_r[qsel]  <= (cfg_data[9:8] == 2'd3) ? 2'd2 : cfg_data[9:8];
                base_r[qsel] <= cfg_data[16 +: AW];
                rptr_r[qsel] <= '0;
                wptr_r[qsel] <= '0;
                cnt_r[qsel]  <= '0;
                ovf_r[qsel]  <= 1'b0;
            end
            if (thr_we) begin
                ne_r[qsel]  <= cfg_data[CW-1:0];
                nf_r[qsel]  <= cfg_data[8 +: CW];
                ien_r[qsel] <= cfg_data[16 +: FLAG_W];
            end
            if (ovf_set) ovf_r[qsel] <= 1'b1;
            if (ovf_clr) ovf_r[qsel] <= 1'b0;
            if (push_done) begin
                wptr_r[qsel] <= step(wptr_r[qsel], nent_r[qsel]);
                cnt_r[qsel]  <= cnt_r[qsel] + 1'b1;
            end
            if (pop_done) begin
                rptr_r[qsel] <= step(rptr_r[qsel], nent_r[qsel]);
                cnt_r[qsel]  <= cnt_r[qsel] - 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_flag
        qm_flags_t fl;
        assign fl.empty      = (cnt_r[g] == '0);
        assign fl.full       = (cnt_r[g] == nent_r[g]);
        assign fl.near_empty = (cnt_r[g] <= ne_r[g]);
        assign fl.near_full  = (cnt_r[g] >= nf_r[g]);
        assign flags_all[g*FLAG_W +: FLAG_W] = fl;
        assign ien_all[g*FLAG_W +: FLAG_W]   = ien_r[g];
    end

    assign sel_base  = base_r[qsel];
    assign sel_nent  = nent_r[qsel];
    assign sel_esz   = esz_r[qsel];
    assign sel_rptr  = rptr_r[qsel];
    assign sel_wptr  = wptr_r[qsel];
    assign sel_cnt   = cnt_r[qsel];
    assign sel_ne_th = ne_r[qsel];
    assign sel_nf_th = nf_r[qsel];
    assign sel_ien   = ien_r[qsel];
    assign sel_ovf   = ovf_r[qsel];
    assign sel_flags = flags_all[{qsel, 2'b00} +: FLAG_W];
endmodule

// File: rtl/qmgr_irq.sv
module qmgr_irq import qmgr_pkg::*; #(
    parameter int unsigned NQ = 64,
    localparam int unsigned HALF = NQ / 2
) (
    input  logic [NQ*FLAG_W-1:0]   flags_all,
    input  logic [NQ*FLAG_W-1:0]   ien_all,
    output logic [HALF*FLAG_W-1:0] flag_lo,
    output logic                   evt_hi,
    output logic                   irq_lo,
    output logic                   irq_hi
);
    logic [NQ-1:0]   want;
    logic [HALF-1:0] hi_busy;

    for (genvar g = 0; g < NQ; g++) begin : g_want
        assign want[g] = |(ien_all[g*FLAG_W +: FLAG_W] & flags_all[g*FLAG_W +: FLAG_W]);
    end

    for (genvar g = 0; g < HALF; g++) begin : g_hi
        assign hi_busy[g] = ~flags_all[(HALF + g)*FLAG_W];
    end

    assign flag_lo = flags_all[HALF*FLAG_W-1:0];
    assign evt_hi  = |hi_busy;
    assign irq_lo  = |want[HALF-1:0];
    assign irq_hi  = |want[NQ-1:HALF];
endmodule

// File: rtl/qmgr_top.sv
module qmgr_top import qmgr_pkg::*; #(
    parameter int unsigned NQ        = 64,
    parameter int unsigned MEM_WORDS = 2048,
    parameter int unsigned CW        = 8,
    localparam int unsigned AW       = $clog2(MEM_WORDS),
    localparam int unsigned QW       = $clog2(NQ),
    localparam int unsigned OFS_W    = (AW > QW + 2) ? AW : QW + 2,
    localparam int unsigned BUS_AW   = OFS_W + 2,
    localparam int unsigned BUS_DW   = WORD_W * LANES,
    localparam int unsigned LANE_W   = $clog2(LANES),
    localparam int unsigned FLO_W    = (NQ / 2) * FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [FLO_W-1:0]  flag_lo,
    output logic              evt_hi,
    output logic              irq_lo,
    output logic              irq_hi
);
    qm_state_e  st_q, st_d;
    qm_region_e rgn;
    logic [1:0] cfg_sel;

    logic              op_we_q;
    logic [QW-1:0]     op_q_q, qsel;
    logic [BUS_DW-1:0] op_data_q, rdata_q;
    logic [LANE_W-1:0] idx_q, last_idx;

    logic geom_we, thr_we, ovf_clr, ovf_set, push_done, pop_done;
    logic              mem_we;
    logic [AW-1:0]     mem_addr, q_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata, read_word;

    logic [AW-1:0]     sel_base;
    logic [CW-1:0]     sel_nent, sel_rptr, sel_wptr, sel_cnt, sel_ne_th, sel_nf_th, ptr;
    logic [1:0]        sel_esz;
    logic [FLAG_W-1:0] sel_ien;
    logic              sel_ovf;
    qm_flags_t         sel_flags;
    logic [NQ*FLAG_W-1:0] flags_all, ien_all;

    assign rgn     = qm_region_e'(bus_addr[BUS_AW-1 -: 2]);
    assign cfg_sel = bus_addr[1:0];
    assign qsel    = (st_q != ST_IDLE) ? op_q_q
                   : (rgn == RG_CFG) ? bus_addr[QW+1:2] : bus_addr[QW-1:0];

    always_comb begin
        unique case (sel_esz)
            2'd0:    last_idx = LANE_W'(0);
            2'd1:    last_idx = LANE_W'(1);
            default: last_idx = LANE_W'(LANES - 1);
        endcase
    end

    assign ptr    = op_we_q ? sel_wptr : sel_rptr;
    assign q_addr = sel_base + AW'({2'b00, ptr} << sel_esz) + AW'(idx_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and strobes
    always_comb begin
        st_d      = st_q;
        geom_we   = 1'b0;
        thr_we    = 1'b0;
        ovf_clr   = 1'b0;
        ovf_set   = 1'b0;
        push_done = 1'b0;
        pop_done  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q_addr;
        mem_wdata = op_data_q[idx_q*WORD_W +: WORD_W];
        unique case (st_q)
            ST_IDLE: if (bus_req) begin
                st_d = ST_DONE;
                unique case (rgn)
                    RG_QUEUE: begin
                        if (bus_we) begin
                            if (sel_flags.full) ovf_set = 1'b1;
                            else                st_d    = ST_MOVE;
                        end else if (!sel_flags.empty) begin
                            st_d = ST_MOVE;
                        end
                    end
                    RG_CFG: begin
                        geom_we = bus_we && (cfg_sel == 2'd0);
                        thr_we  = bus_we && (cfg_sel == 2'd1);
                        ovf_clr = bus_we && (cfg_sel == 2'd2);
                    end
                    RG_RAW: begin
                        mem_addr  = bus_addr[AW-1:0];
                        mem_we    = bus_we;
                        mem_wdata = bus_wdata[WORD_W-1:0];
                    end
                    default: ;
                endcase
            end
            ST_MOVE: begin
                mem_we = op_we_q;
                if (idx_q == last_idx) begin
                    st_d      = ST_DONE;
                    push_done = op_we_q;
                    pop_done  = !op_we_q;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // single-word read sources
    always_comb begin
        read_word = '0;
        if (!bus_we && rgn == RG_CFG) begin
            unique case (cfg_sel)
                2'd0: begin
                    read_word[CW-1:0]   = sel_nent;
                    read_word[9:8]      = sel_esz;
                    read_word[16 +: AW] = sel_base;
                end
                2'd1: begin
                    read_word[CW-1:0]       = sel_ne_th;
                    read_word[8 +: CW]      = sel_nf_th;
                    read_word[16 +: FLAG_W] = sel_ien;
                end
                2'd2: begin
                    read_word[CW-1:0] = sel_cnt;
                    read_word[16]     = sel_flags.empty;
                    read_word[17]     = sel_flags.full;
                    read_word[18]     = sel_flags.near_empty;
                    read_word[19]     = sel_flags.near_full;
                    read_word[20]     = sel_ovf;
                end
                default: read_word = '0;
            endcase
        end else if (!bus_we && rgn == RG_RAW) begin
            read_word = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_we_q   <= 1'b0;
            op_q_q    <= '0;
            op_data_q <= '0;
            idx_q     <= '0;
            rdata_q   <= '0;
        end else if (st_q == ST_IDLE && bus_req) begin
            op_we_q   <= bus_we;
            op_q_q    <= qsel;
            op_data_q <= bus_wdata;
            idx_q     <= '0;
            rdata_q   <= BUS_DW'(read_word);
        end else if (st_q == ST_MOVE) begin
            idx_q <= idx_q + 1'b1;
            if (!op_we_q) rdata_q[idx_q*WORD_W +: WORD_W] <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        bus_ready = (st_q == ST_IDLE);
        bus_ack   = (st_q == ST_DONE);
        bus_rdata = rdata_q;
    end

    qmgr_sram #(.WORDS(MEM_WORDS), .DW(WORD_W)) u_sram (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    qmgr_qfile #(.NQ(NQ), .AW(AW), .CW(CW)) u_qfile (
        .clk(clk), .rst_n(rst_n), .qsel(qsel),
        .geom_we(geom_we), .thr_we(thr_we), .ovf_clr(ovf_clr), .ovf_set(ovf_set),
        .push_done(push_done), .pop_done(pop_done),
        .cfg_data(bus_wdata[16+AW-1:0]),
        .sel_base(sel_base), .sel_nent(sel_nent), .sel_esz(sel_esz),
        .sel_rptr(sel_rptr), .sel_wptr(sel_wptr), .sel_cnt(sel_cnt),
        .sel_ne_th(sel_ne_th), .sel_nf_th(sel_nf_th), .sel_ien(sel_ien),
        .sel_ovf(sel_ovf), .sel_flags(sel_flags),
        .flags_all(flags_all), .ien_all(ien_all)
    );

    qmgr_irq #(.NQ(NQ)) u_irq (
        .flags_all(flags_all), .ien_all(ien_all),
        .flag_lo(flag_lo), .evt_hi(evt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );
endmodule

// File: rtl/qmgr_chk.sv
module qmgr_chk #(
    parameter int unsigned NQ = 64,
    localparam int unsigned HALF = NQ / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              bus_ack,
    input logic [HALF*4-1:0] flag_lo
);
    logic [HALF-1:0] empty_v, near_v;

    for (genvar g = 0; g < HALF; g++) begin : g_split
        assign empty_v[g] = flag_lo[g*4];
        assign near_v[g]  = flag_lo[g*4 + 1];
    end

    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_ack_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !bus_ready);

    assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_req) |=> !bus_ready);

    assert_ready_return_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> bus_ready);

    // an empty queue always has count 0 <= any near-empty threshold
    assert_empty_near_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_v & ~near_v) == '0);
endmodule

bind qmgr_top qmgr_chk #(.NQ(NQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
    .bus_ack(bus_ack), .flag_lo(flag_lo)
);

// File: tb/sim_qmgr_top.sv
module sim_qmgr_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [12:0]  bus_addr = '0;
    logic [127:0] bus_wdata = '0;
    logic         bus_ready, bus_ack, evt_hi, irq_lo, irq_hi;
    logic [127:0] bus_rdata, flag_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit           care;
        logic [127:0] val;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    qmgr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .flag_lo(flag_lo),
        .evt_hi(evt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] qa(input int q);
        return 13'(q);
    endfunction
    function automatic logic [12:0] ca(input int q, input int s);
        return 13'h0800 | 13'(q * 4 + s);
    endfunction
    function automatic logic [12:0] ra(input int a);
        return 13'h1000 | 13'(a);
    endfunction
    function automatic logic [127:0] geo(input int nent, input int esz, input int base);
        return 128'(nent) | (128'(esz) << 8) | (128'(base) << 16);
    endfunction
    function automatic logic [127:0] thr(input int ne, input int nf, input int ien);
        return 128'(ne) | (128'(nf) << 8) | (128'(ien) << 16);
    endfunction
    function automatic logic [127:0] stw(input int cnt, input bit e, input bit f,
                                         input bit ne, input bit nf, input bit ov);
        logic [127:0] r;
        r = '0;
        r[7:0] = 8'(cnt);
        r[16] = e; r[17] = f; r[18] = ne; r[19] = nf; r[20] = ov;
        return r;
    endfunction

    // driver: queue the expectation, then run one access
    task automatic op(input bit we, input logic [12:0] a, input logic [127:0] d,
                      input bit care, input logic [127:0] e, input string tag);
        exp_q.push_back('{care, e, tag});
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_ack) @(negedge clk);
        @(negedge clk);
        check("R12 ack pulse then ready", {126'b0, bus_ack, bus_ready}, 128'b01);
    endtask

    task automatic wr(input logic [12:0] a, input logic [127:0] d);
        op(1'b1, a, d, 1'b0, '0, "write");
    endtask
    task automatic rd(input logic [12:0] a, input logic [127:0] e, input string tag);
        op(1'b0, a, '0, 1'b1, e, tag);
    endtask

    // monitor: compare results as acknowledges appear
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected ack", 128'd1, 128'd0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (it.care) check(it.tag, bus_rdata, it.val);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 128'(bus_ready), 128'd1);
        check("R1 irq/evt", {125'b0, evt_hi, irq_lo, irq_hi}, 128'd0);
        check("R1 flag_lo", flag_lo, {32{4'hB}});
        rd(ca(5, 0), 128'd0, "R1 geometry reset");
        rd(ca(5, 1), 128'h0000FF00, "R1 threshold reset");

        // R2 geometry write and read back, queue 0: 4 entries, 1 word, base 0x100
        wr(ca(0, 0), geo(4, 0, 'h100));
        rd(ca(0, 0), geo(4, 0, 'h100), "R2 geometry readback");
        rd(ca(0, 2), stw(0, 1, 0, 1, 0, 0), "R7 empty status");
        wr(ca(0, 1), thr(1, 3, 0));
        rd(ca(0, 1), thr(1, 3, 0), "R7 threshold readback");

        wr(qa(0), 128'h11); wr(qa(0), 128'h22); wr(qa(0), 128'h33);
        rd(ca(0, 2), stw(3, 0, 0, 0, 1, 0), "R7 count 3 near-full");
        check("R8 flag group q0", 128'(flag_lo[3:0]), 128'h4);
        wr(qa(0), 128'h44);
        wr(qa(0), 128'h55);
        rd(ca(0, 2), stw(4, 0, 1, 0, 1, 1), "R6 full push discarded, overflow set");
        check("R8 flag group q0 full", 128'(flag_lo[3:0]), 128'hC);
        rd(qa(0), 128'h11, "R3 order 1");
        rd(qa(0), 128'h22, "R3 order 2");
        rd(qa(0), 128'h33, "R3 order 3");
        rd(qa(0), 128'h44, "R6 discarded push absent");
        rd(qa(0), 128'h0, "R5 empty pop zero");
        rd(ca(0, 2), stw(0, 1, 0, 1, 0, 1), "R5 status after empty pop");
        wr(ca(0, 2), '0);
        rd(ca(0, 2), stw(0, 1, 0, 1, 0, 0), "R6 overflow cleared");

        // R4 wrap: slots 0..2, pop two, then slots 3 and 0
        wr(qa(0), 128'hA1); wr(qa(0), 128'hB2); wr(qa(0), 128'hC3);
        rd(qa(0), 128'hA1, "R5 pointers unchanged after empty pop");
        rd(qa(0), 128'hB2, "R4 pop B");
        wr(qa(0), 128'hD4); wr(qa(0), 128'hE5);
        rd(ra('h100), 128'hE5, "R4 wrapped entry at base");
        rd(ra('h103), 128'hD4, "R4 last slot");
        rd(qa(0), 128'hC3, "R4 pop C");
        rd(qa(0), 128'hD4, "R4 pop D");
        rd(qa(0), 128'hE5, "R4 pop E after wrap");

        // two-word entries, queue 1
        wr(ca(1, 0), geo(2, 1, 'h200));
        wr(qa(1), 128'hFFFF0000_EEEE0000_00000102_00000101);
        wr(qa(1), 128'h12345678_9ABCDEF0_00000202_00000201);
        rd(ra('h202), 128'h201, "R4 second entry word 0");
        rd(ra('h203), 128'h202, "R4 second entry word 1");
        wr(qa(1), 128'h9);
        rd(qa(1), 128'h00000102_00000101, "R3 two-word pop, upper lanes zero");
        wr(ca(1, 0), geo(2, 1, 'h200));
        rd(ca(1, 2), stw(0, 1, 0, 1, 0, 0), "R2 geometry write resets queue");

        // four-word entries, queue 2
        wr(ca(2, 0), geo(3, 2, 'h300));
        wr(qa(2), 128'h44444444_33333333_22222222_11111111);
        rd(ra('h303), 128'h44444444, "R4 four-word layout");
        rd(qa(2), 128'h44444444_33333333_22222222_11111111, "R3 four-word pop");

        // R10 lower interrupt from empty flag
        wr(ca(0, 1), thr(1, 3, 1));
        check("R10 irq_lo on empty enable", {126'b0, irq_lo, irq_hi}, 128'b10);
        wr(ca(0, 1), thr(1, 3, 0));
        check("R10 irq_lo disabled", 128'(irq_lo), 128'd0);

        // upper queue 40: event and interrupt
        wr(ca(40, 0), geo(2, 0, 'h400));
        wr(ca(40, 1), thr(0, 1, 4));
        check("R9 evt_hi idle", 128'(evt_hi), 128'd0);
        wr(qa(40), 128'h77);
        check("R9 evt_hi on entry", 128'(evt_hi), 128'd1);
        check("R10 irq_hi near-full", {126'b0, irq_lo, irq_hi}, 128'b01);
        rd(qa(40), 128'h77, "R3 upper pop");
        check("R9 evt_hi drained", {126'b0, evt_hi, irq_hi}, 128'b00);

        // R11 raw access
        wr(ra('h7F0), 128'hDEADBEEF);
        rd(ra('h7F0), 128'hDEADBEEF, "R11 raw readback");

        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 128'(exp_q.size()), 128'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule